// File: doc/BRIEF.md
# SPI Target Controller with Shared-Buffer FIFOs

This block is the target end of an SPI link. An external controller drives the serial clock and chip select. Bytes arriving on the data-in line are stored in a receive FIFO. Bytes for the controller are taken from a transmit FIFO and shifted out on the data-out line. Both FIFOs live in one dual-port byte memory of `2 << HALF_AW` bytes. The lower half is the receive queue and the upper half is the transmit queue.

Each queue has two pointers. The serial engine advances the receive head and the transmit tail. The CPU owns the receive tail and the transmit head, and moves them by writing registers. Every pointer has one bit more than the half-buffer address. That top bit is a lap marker, which lets a full queue be told apart from an empty one.

A simple CPU port has a one-cycle read latency. It can read the buffer with byte, halfword or word accesses. It can write the buffer only with whole words. It also reads and writes the pointer, status and level registers. A level interrupt tells the CPU when received data is ready.

Top module: `spi_shared_fifo_slave`

## Requirements
- R1: After reset, all four pointers, the level register, the sticky status bits and `irq` read 0, and the status register reads 0x500 (receive-empty bit 8 and transmit-empty bit 10 set).
- R2: The link uses SPI mode 0, most significant bit first. Data-in is sampled on the rising SCK edge. Each completed byte is written to buffer byte `{0, rx_head[HALF_AW-1:0]}`, and the receive head then advances by one.
- R3: The byte at buffer address `{1, tx_tail[HALF_AW-1:0]}` is presented on data-out, most significant bit first, before the first rising edge of a byte. Bits change on falling edges. The transmit tail advances once, when a real byte completes.
- R4: When the transmit queue is empty at the start of a byte, the target shifts out 0xFF, leaves the transmit tail unchanged, and sets sticky underrun status bit 1 when that byte completes.
- R5: When the receive queue is full, a completed byte is dropped. The receive head and the buffer are left unchanged, and sticky overflow status bit 0 is set.
- R6: A queue is empty when all pointer bits match. It is full when the low `HALF_AW` bits match and the lap bits differ. Status bits 8, 9, 10 and 11 report receive empty, receive full, transmit empty and transmit full.
- R7: CPU writes to the buffer region (address bit `HALF_AW+1` = 0) take effect only when the access is a word (`cpu_size` = 2). Word data is stored little-endian. Byte and halfword writes leave the buffer unchanged.
- R8: CPU reads of the buffer return, one cycle later, a zero-extended byte (`cpu_size` 0), an aligned halfword (`cpu_size` 1) or an aligned word (`cpu_size` 2), all little-endian.
- R9: Raising chip select partway through a byte discards the partial bits. The next frame starts on a byte boundary, and neither pointer moves.
- R10: `irq` is high while the level register is nonzero and the receive fill (`rx_head - rx_tail`) is at least that level.
- R11: Raising chip select while the receive queue holds data sets sticky frame bit 2, which drives `irq` high. Writing 1 to status bits 0 to 2 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| cpu_req | input | 1 | CPU access strobe, one cycle per access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | HALF_AW+2 | Byte address. Top bit 1 selects registers: word 0 rx head, 1 rx tail, 2 tx head, 3 tx tail, 4 status, 5 level |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid the cycle after the request |
| irq | output | 1 | Level receive interrupt |

## Verification
Filling the receive queue from the serial side would take a whole half-buffer of serial traffic. The hardest condition to reach is therefore overflow. The bench reaches it cheaply instead. It writes the CPU-owned receive tail so that it equals the hardware head with the lap bit flipped, which makes the queue report full at once. Before that, it plants a known word at the slot the next byte would land in, so that a dropped byte stays visible in the buffer. Underrun is reached by draining the transmit queue mid-frame and clocking one more byte. Partial-byte discard is reached by dropping chip select after four clocks, then checking that the next full byte lands intact.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        RG_RX_HEAD = 3'd0,
        RG_RX_TAIL = 3'd1,
        RG_TX_HEAD = 3'd2,
        RG_TX_TAIL = 3'd3,
        RG_STATUS  = 3'd4,
        RG_LEVEL   = 3'd5
    } reg_idx_e;

    localparam int ST_OVF      = 0;
    localparam int ST_UNDR     = 1;
    localparam int ST_FRAME    = 2;
    localparam int ST_RX_EMPTY = 8;
    localparam int ST_RX_FULL  = 9;
    localparam int ST_TX_EMPTY = 10;
    localparam int ST_TX_FULL  = 11;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    // Events from the serial engine to the pointer logic, one-cycle pulses
    typedef struct packed {
        logic       push;       // a received byte is complete
        logic [7:0] data;       // that byte
        logic       pop;        // a real transmit byte was fully sent
        logic       underrun;   // an idle byte was fully sent
        logic       frame_end;  // chip select went inactive
    } link_evt_t;

    // Select the bytes a read of the given size returns from a word
    function automatic logic [31:0] lane_pick(logic [31:0] w, logic [1:0] off, logic [1:0] sz);
        logic [31:0] r;
        case (sz)
            ACC_BYTE: r = {24'b0, w[8*off +: 8]};
            ACC_HALF: r = {16'b0, w[16*off[1] +: 16]};
            default:  r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_buf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sck,
    input  logic      cs_n,
    input  logic      mosi,
    input  logic      tx_avail,
    input  logic [7:0] tx_peek,
    output logic      miso,
    output link_evt_t evt
);
    localparam int SYNC = 3;

    logic [SYNC-1:0] sck_q, cs_q;
    logic [1:0]      mosi_q;
    logic            sck_rise, sck_fall, cs_act, cs_start, cs_end;

    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       cur_real;   // the byte in tx_sh came from the queue
    logic       reload;     // fetch the next byte at the coming falling edge

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[SYNC-2:0], sck};
            cs_q   <= {cs_q[SYNC-2:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    always_comb begin
        sck_rise = sck_q[1] & ~sck_q[2];
        sck_fall = ~sck_q[1] & sck_q[2];
        cs_act   = ~cs_q[1];
        cs_start = ~cs_q[1] & cs_q[2];
        cs_end   = cs_q[1] & ~cs_q[2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= IDLE_BYTE;
            cur_real <= 1'b0;
            reload   <= 1'b0;
            evt      <= '0;
        end else begin
            evt <= '0;
            if (cs_start) begin
                bit_cnt  <= '0;
                reload   <= 1'b0;
                cur_real <= tx_avail;
                tx_sh    <= tx_avail ? tx_peek : IDLE_BYTE;
            end else if (cs_end) begin
                bit_cnt       <= '0;
                reload        <= 1'b0;
                evt.frame_end <= 1'b1;
            end else if (cs_act) begin
                if (sck_rise) begin
                    rx_sh   <= {rx_sh[5:0], mosi_q[1]};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        evt.push     <= 1'b1;
                        evt.data     <= {rx_sh, mosi_q[1]};
                        evt.pop      <= cur_real;
                        evt.underrun <= ~cur_real;
                        reload       <= 1'b1;
                    end
                end else if (sck_fall) begin
                    if (reload) begin
                        reload   <= 1'b0;
                        cur_real <= tx_avail;
                        tx_sh    <= tx_avail ? tx_peek : IDLE_BYTE;
                    end else begin
                        tx_sh <= {tx_sh[6:0], 1'b1};
                    end
                end
            end
        end
    end

    assign miso = tx_sh[7];

endmodule

// File: rtl/spi_dual_ram.sv
module spi_dual_ram #(
    parameter int HALF_AW = 10
) (
    input  logic                 clk,
    // serial-side port: byte write, byte read
    input  logic                 s_we,
    input  logic [HALF_AW:0]     s_waddr,
    input  logic [7:0]           s_wdata,
    input  logic [HALF_AW:0]     s_raddr,
    output logic [7:0]           s_rdata,
    // CPU-side port: word write, word read
    input  logic                 c_we,
    input  logic [HALF_AW-2:0]   c_widx,
    input  logic [31:0]          c_wdata,
    input  logic [HALF_AW-2:0]   c_ridx,
    output logic [31:0]          c_rdata
);
    localparam int DEPTH = 2 << HALF_AW;
    localparam int LANES = 4;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (s_we)
            mem[s_waddr] <= s_wdata;
        if (c_we) begin
            for (int l = 0; l < LANES; l++)
                mem[{c_widx, 2'(l)}] <= c_wdata[8*l +: 8];
        end
    end

    assign s_rdata = mem[s_raddr];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign c_rdata[8*g +: 8] = mem[{c_ridx, 2'(g)}];
    end

endmodule

// File: rtl/spi_ptr_ctl.sv
module spi_ptr_ctl
    import spi_buf_pkg::*;
#(
    parameter int HALF_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  link_evt_t          evt,
    input  logic               reg_we,
    input  logic [2:0]         reg_idx,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               ram_we,
    output logic [HALF_AW:0]   ram_waddr,
    output logic [HALF_AW:0]   tx_addr,
    output logic               tx_avail,
    output logic [HALF_AW:0]   rx_head,
    output logic [HALF_AW:0]   rx_tail,
    output logic [HALF_AW:0]   tx_head,
    output logic [HALF_AW:0]   tx_tail,
    output logic [HALF_AW:0]   level,
    output logic               frame_flag,
    output logic               irq
);
    localparam int PTR_W = HALF_AW + 1;

    logic           rx_empty, rx_full, tx_empty, tx_full;
    logic [PTR_W-1:0] rx_fill;
    logic           st_ovf, st_undr;
    logic           push_ok;
    logic [2:0]     w1c;

    always_comb begin
        rx_empty = (rx_head == rx_tail);
        rx_full  = (rx_head[HALF_AW-1:0] == rx_tail[HALF_AW-1:0]) &&
                   (rx_head[HALF_AW] != rx_tail[HALF_AW]);
        tx_empty = (tx_head == tx_tail);
        tx_full  = (tx_head[HALF_AW-1:0] == tx_tail[HALF_AW-1:0]) &&
                   (tx_head[HALF_AW] != tx_tail[HALF_AW]);
        rx_fill  = rx_head - rx_tail;
        push_ok  = evt.push & ~rx_full;
        w1c      = (reg_we && reg_idx == RG_STATUS) ? reg_wdata[2:0] : 3'b000;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_head    <= '0;
            rx_tail    <= '0;
            tx_head    <= '0;
            tx_tail    <= '0;
            level      <= '0;
            st_ovf     <= 1'b0;
            st_undr    <= 1'b0;
            frame_flag <= 1'b0;
        end else begin
            if (push_ok)
                rx_head <= rx_head + 1'b1;
            if (evt.pop)
                tx_tail <= tx_tail + 1'b1;
            st_ovf     <= (evt.push & rx_full) | (st_ovf & ~w1c[ST_OVF]);
            st_undr    <= evt.underrun | (st_undr & ~w1c[ST_UNDR]);
            frame_flag <= (evt.frame_end & ~rx_empty) | (frame_flag & ~w1c[ST_FRAME]);
            if (reg_we) begin
                case (reg_idx)
                    RG_RX_TAIL: rx_tail <= reg_wdata[PTR_W-1:0];
                    RG_TX_HEAD: tx_head <= reg_wdata[PTR_W-1:0];
                    RG_LEVEL:   level   <= reg_wdata[PTR_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            RG_RX_HEAD: reg_rdata[PTR_W-1:0] = rx_head;
            RG_RX_TAIL: reg_rdata[PTR_W-1:0] = rx_tail;
            RG_TX_HEAD: reg_rdata[PTR_W-1:0] = tx_head;
            RG_TX_TAIL: reg_rdata[PTR_W-1:0] = tx_tail;
            RG_LEVEL:   reg_rdata[PTR_W-1:0] = level;
            RG_STATUS: begin
                reg_rdata[ST_OVF]      = st_ovf;
                reg_rdata[ST_UNDR]     = st_undr;
                reg_rdata[ST_FRAME]    = frame_flag;
                reg_rdata[ST_RX_EMPTY] = rx_empty;
                reg_rdata[ST_RX_FULL]  = rx_full;
                reg_rdata[ST_TX_EMPTY] = tx_empty;
                reg_rdata[ST_TX_FULL]  = tx_full;
            end
            default: ;
        endcase
    end

    assign ram_we    = push_ok;
    assign ram_waddr = {1'b0, rx_head[HALF_AW-1:0]};
    assign tx_addr   = {1'b1, tx_tail[HALF_AW-1:0]};
    assign tx_avail  = ~tx_empty;
    assign irq       = frame_flag | ((level != '0) && (rx_fill >= level));

endmodule

// File: rtl/spi_shared_fifo_slave.sv
module spi_shared_fifo_slave
    import spi_buf_pkg::*;
#(
    parameter int HALF_AW = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 spi_sck,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    input  logic                 cpu_req,
    input  logic                 cpu_wr,
    input  logic [1:0]           cpu_size,
    input  logic [HALF_AW+1:0]   cpu_addr,
    input  logic [31:0]          cpu_wdata,
    output logic [31:0]          cpu_rdata,
    output logic                 irq
);
    localparam int PTR_W = HALF_AW + 1;
    localparam int AW    = HALF_AW + 2;

    link_evt_t        evt;
    logic             tx_avail;
    logic [7:0]       tx_peek;
    logic             ram_we;
    logic [PTR_W-1:0] ram_waddr, tx_addr;
    logic [PTR_W-1:0] rx_head, rx_tail, tx_head, tx_tail, level;
    logic             frame_flag;
    logic [31:0]      reg_rdata, ram_word;
    logic             in_regs, buf_wr, reg_wr;

    assign in_regs = cpu_addr[AW-1];
    assign buf_wr  = cpu_req & cpu_wr & ~in_regs & (cpu_size == ACC_WORD);
    assign reg_wr  = cpu_req & cpu_wr & in_regs;

    spi_bit_engine i_engine (
        .clk      (clk),
        .rst      (rst),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .tx_avail (tx_avail),
        .tx_peek  (tx_peek),
        .miso     (spi_miso),
        .evt      (evt)
    );

    spi_dual_ram #(.HALF_AW(HALF_AW)) i_ram (
        .clk     (clk),
        .s_we    (ram_we),
        .s_waddr (ram_waddr),
        .s_wdata (evt.data),
        .s_raddr (tx_addr),
        .s_rdata (tx_peek),
        .c_we    (buf_wr),
        .c_widx  (cpu_addr[HALF_AW:2]),
        .c_wdata (cpu_wdata),
        .c_ridx  (cpu_addr[HALF_AW:2]),
        .c_rdata (ram_word)
    );

    spi_ptr_ctl #(.HALF_AW(HALF_AW)) i_ptr (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .reg_we     (reg_wr),
        .reg_idx    (cpu_addr[4:2]),
        .reg_wdata  (cpu_wdata),
        .reg_rdata  (reg_rdata),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .tx_addr    (tx_addr),
        .tx_avail   (tx_avail),
        .rx_head    (rx_head),
        .rx_tail    (rx_tail),
        .tx_head    (tx_head),
        .tx_tail    (tx_tail),
        .level      (level),
        .frame_flag (frame_flag),
        .irq        (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cpu_rdata <= '0;
        else if (cpu_req && !cpu_wr)
            cpu_rdata <= in_regs ? reg_rdata
                                 : lane_pick(ram_word, cpu_addr[1:0], cpu_size);
    end

endmodule

// File: rtl/spi_shared_fifo_slave_chk.sv
module spi_shared_fifo_slave_chk #(
    parameter int PTR_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic [PTR_W-1:0] rx_head,
    input logic [PTR_W-1:0] rx_tail,
    input logic [PTR_W-1:0] tx_head,
    input logic [PTR_W-1:0] tx_tail,
    input logic [PTR_W-1:0] level,
    input logic             frame_flag,
    input logic             irq
);
    localparam int LAP = PTR_W - 1;

    logic             rx_full_c, tx_empty_c;
    logic [PTR_W-1:0] fill_c;

    assign rx_full_c  = (rx_head[LAP-1:0] == rx_tail[LAP-1:0]) && (rx_head[LAP] != rx_tail[LAP]);
    assign tx_empty_c = (tx_head == tx_tail);
    assign fill_c     = rx_head - rx_tail;

    // R2: the hardware receive head only ever steps forward by one
    a_r2_head_single_step: assert property (@(posedge clk) disable iff (rst)
        (rx_head != $past(rx_head)) |-> (rx_head == PTR_W'($past(rx_head) + 1'b1)));

    // R3: the hardware transmit tail only ever steps forward by one
    a_r3_tail_single_step: assert property (@(posedge clk) disable iff (rst)
        (tx_tail != $past(tx_tail)) |-> (tx_tail == PTR_W'($past(tx_tail) + 1'b1)));

    // R4: an empty transmit queue is never popped
    a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        tx_empty_c |=> (tx_tail == $past(tx_tail)));

    // R5: a full receive queue is never written
    a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        rx_full_c |=> (rx_head == $past(rx_head)));

    // R10: the fill level at or above a nonzero threshold drives the interrupt
    a_r10_level_irq: assert property (@(posedge clk) disable iff (rst)
        ((level != '0) && (fill_c >= level)) |-> irq);

    // R11: a pending frame-end flag drives the interrupt
    a_r11_frame_irq: assert property (@(posedge clk) disable iff (rst)
        frame_flag |-> irq);

endmodule

bind spi_shared_fifo_slave spi_shared_fifo_slave_chk #(.PTR_W(PTR_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_head    (rx_head),
    .rx_tail    (rx_tail),
    .tx_head    (tx_head),
    .tx_tail    (tx_tail),
    .level      (level),
    .frame_flag (frame_flag),
    .irq        (irq)
);

// File: tb/test_spi_shared_fifo_slave.sv
`timescale 1ns/1ps
module test_spi_shared_fifo_slave;

    localparam int HALF_AW = 10;
    localparam int AW      = HALF_AW + 2;
    localparam logic [AW-1:0] TXB  = 12'h400;
    localparam logic [AW-1:0] REGB = 12'h800;
    localparam logic [AW-1:0] A_RXH = REGB + 12'h0;
    localparam logic [AW-1:0] A_RXT = REGB + 12'h4;
    localparam logic [AW-1:0] A_TXH = REGB + 12'h8;
    localparam logic [AW-1:0] A_TXT = REGB + 12'hC;
    localparam logic [AW-1:0] A_ST  = REGB + 12'h10;
    localparam logic [AW-1:0] A_LVL = REGB + 12'h14;
    localparam int HALF_SCK = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso;
    logic cpu_req = 1'b0, cpu_wr = 1'b0;
    logic [1:0] cpu_size = 2'd2;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic irq;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    logic [7:0] got_byte;
    event byte_done;

    always #2 clk = ~clk;

    spi_shared_fifo_slave #(.HALF_AW(HALF_AW)) i_spi_shared_fifo_slave (
        .clk(clk), .rst(rst),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_size = sz; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [AW-1:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = a; cpu_size = sz;
        @(negedge clk);
        d = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [AW-1:0] a, input logic [1:0] sz,
                              input logic [31:0] mask, input logic [31:0] exp);
        logic [31:0] d;
        cpu_read(a, sz, d);
        check(req, d & mask, exp);
    endtask

    task automatic spi_begin();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF_SCK) @(negedge clk);
    endtask

    task automatic spi_end();
        repeat (HALF_SCK) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (HALF_SCK) @(negedge clk);
    endtask

    // Driver: queue the expected data-out byte, then clock one byte in mode 0
    task automatic spi_byte(input logic [7:0] v, input logic [7:0] exp);
        logic [7:0] cap = '0;
        exp_q.push_back(exp);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = v[b];
            repeat (HALF_SCK) @(negedge clk);
            spi_sck = 1'b1;
            cap = {cap[6:0], spi_miso};
            repeat (HALF_SCK) @(negedge clk);
            spi_sck = 1'b0;
        end
        got_byte = cap;
        ->byte_done;
    endtask

    task automatic spi_bits(input int n);
        for (int b = 0; b < n; b++) begin
            spi_mosi = 1'b1;
            repeat (HALF_SCK) @(negedge clk);
            spi_sck = 1'b1;
            repeat (HALF_SCK) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    // Monitor: compare each completed data-out byte with the scoreboard
    initial begin
        forever begin
            @(byte_done);
            if (exp_q.size() == 0)
                check("R3 unexpected byte", {24'b0, got_byte}, 32'hFFFF_FFFF);
            else
                check("R3/R4 data-out byte", {24'b0, got_byte}, {24'b0, exp_q.pop_front()});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        read_check("R1 rx head", A_RXH, 2'd2, 32'hFFFF_FFFF, 32'h0);
        read_check("R1 tx tail", A_TXT, 2'd2, 32'hFFFF_FFFF, 32'h0);
        read_check("R1 level",   A_LVL, 2'd2, 32'hFFFF_FFFF, 32'h0);
        read_check("R1 R6 status", A_ST, 2'd2, 32'hFFFF_FFFF, 32'h500);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R7 word writes into the transmit half, little-endian
        cpu_write(TXB + 12'h0, 2'd2, 32'h4433_2211);
        cpu_write(TXB + 12'h4, 2'd2, 32'h8877_6655);
        cpu_write(A_TXH, 2'd2, 32'd6);
        // R8 read sizes
        read_check("R8 byte read", TXB + 12'h1, 2'd0, 32'hFFFF_FFFF, 32'h22);
        read_check("R8 half read", TXB + 12'h2, 2'd1, 32'hFFFF_FFFF, 32'h4433);
        read_check("R8 word read", TXB + 12'h4, 2'd2, 32'hFFFF_FFFF, 32'h8877_6655);
        // R7 narrow writes ignored
        cpu_write(TXB + 12'h4, 2'd0, 32'h0000_00AB);
        cpu_write(TXB + 12'h6, 2'd1, 32'h0000_CDEF);
        read_check("R7 narrow write ignored", TXB + 12'h4, 2'd2, 32'hFFFF_FFFF, 32'h8877_6655);
        read_check("R6 tx not empty", A_ST, 2'd2, 32'h0000_0C00, 32'h0);

        // R2 R3 a three-byte frame
        spi_begin();
        spi_byte(8'hA5, 8'h11);
        spi_byte(8'h3C, 8'h22);
        spi_byte(8'h0F, 8'h33);
        spi_end();
        read_check("R2 rx head", A_RXH, 2'd2, 32'hFFFF_FFFF, 32'd3);
        read_check("R3 tx tail", A_TXT, 2'd2, 32'hFFFF_FFFF, 32'd3);
        read_check("R2 byte 0", 12'h000, 2'd0, 32'hFFFF_FFFF, 32'hA5);
        read_check("R2 byte 1", 12'h001, 2'd0, 32'hFFFF_FFFF, 32'h3C);
        read_check("R2 byte 2", 12'h002, 2'd0, 32'hFFFF_FFFF, 32'h0F);
        // R11 frame end raises irq, W1C clears it
        read_check("R11 frame bit", A_ST, 2'd2, 32'h4, 32'h4);
        check("R11 irq after frame", {31'b0, irq}, 32'h1);
        cpu_write(A_ST, 2'd2, 32'h4);
        read_check("R11 frame cleared", A_ST, 2'd2, 32'h4, 32'h0);
        check("R11 irq cleared", {31'b0, irq}, 32'h0);

        // R10 threshold of four bytes
        cpu_write(A_LVL, 2'd2, 32'd4);
        spi_begin();
        spi_byte(8'h11, 8'h44);
        repeat (6) @(negedge clk);
        check("R10 irq at threshold", {31'b0, irq}, 32'h1);
        spi_end();
        cpu_write(A_ST, 2'd2, 32'h7);
        check("R10 irq held by level", {31'b0, irq}, 32'h1);
        cpu_write(A_RXT, 2'd2, 32'd4);
        @(negedge clk);
        check("R10 irq drops below level", {31'b0, irq}, 32'h0);

        // R4 underrun: two real bytes then an idle byte
        spi_begin();
        spi_byte(8'h21, 8'h55);
        spi_byte(8'h22, 8'h66);
        spi_byte(8'h23, 8'hFF);
        spi_end();
        read_check("R4 tx tail stops", A_TXT, 2'd2, 32'hFFFF_FFFF, 32'd6);
        read_check("R4 underrun bit", A_ST, 2'd2, 32'h2, 32'h2);
        cpu_write(A_ST, 2'd2, 32'h7);

        // R9 partial byte discarded
        spi_begin();
        spi_bits(4);
        spi_end();
        read_check("R9 rx head after partial", A_RXH, 2'd2, 32'hFFFF_FFFF, 32'd7);
        read_check("R9 no underrun on partial", A_ST, 2'd2, 32'h2, 32'h0);
        spi_begin();
        spi_byte(8'h96, 8'hFF);
        spi_end();
        read_check("R9 next byte aligned", 12'h007, 2'd0, 32'hFFFF_FFFF, 32'h96);
        cpu_write(A_ST, 2'd2, 32'h7);

        // R5 overflow: plant a word, force full by flipping the lap bit
        cpu_write(12'h008, 2'd2, 32'h0000_00C3);
        cpu_write(A_RXT, 2'd2, 32'h408);
        read_check("R6 rx full flag", A_ST, 2'd2, 32'h0000_0300, 32'h0000_0200);
        spi_begin();
        spi_byte(8'h5A, 8'hFF);
        spi_end();
        read_check("R5 rx head held", A_RXH, 2'd2, 32'hFFFF_FFFF, 32'd8);
        read_check("R5 buffer untouched", 12'h008, 2'd0, 32'hFFFF_FFFF, 32'hC3);
        read_check("R5 overflow bit", A_ST, 2'd2, 32'h1, 32'h1);

        // R6 transmit full encoding
        cpu_write(A_TXH, 2'd2, 32'h406);
        read_check("R6 tx full flag", A_ST, 2'd2, 32'h0000_0C00, 32'h0000_0800);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0)
            check("R3 pending bytes", exp_q.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule